// File: doc/BRIEF.md
# Multi-mode PRG bank translator

This block sits in a cartridge controller that can behave like one of three unrelated program-ROM banking schemes, switched at run time. The CPU writes a small style register through a decode in the low address space. It then writes bank registers in the 0x8000–0xFFFF space, and how those writes are decoded depends on the active style. On every CPU access in the upper 32 KB, the block turns the two window bits of the address into a 6-bit 8 KB ROM bank index. The 13-bit offset inside the bank passes through unchanged.

The block also selects how the nametables are mirrored. The third style, the serial-load style, keeps its control and bank registers in a sibling block. Those registers arrive here as plain inputs, and this block only interprets them. The scanline interrupt logic of the indexed style is not part of this block, so writes to its registers are ignored here. The bank and mirroring outputs are combinational from registered state. A write changes them directly after the clock edge that captures it.

Top module: `prg_bank_xlate`

## Requirements
- R1: A write with address bit 15 = 0, bit 14 = 1 and bit 8 = 1 loads the style register from data bits 1:0. The style codes are 0 = simple, 1 = indexed, 2 = serial, 3 = reserved. No other write changes the style.
- R2: In style 0, writes to 0x8000–0x8FFF and 0xA000–0xAFFF load data bits 4:0 into a bank register. Address bit 13 picks the register: 0 for window 0 and 1 for window 1. Windows 2 and 3 always map to banks 0x1E and 0x1F.
- R3: In style 0, a write to 0x9000–0x9FFF loads data bit 0 as the mirroring bit. The mirror output codes are 0 = one-screen low, 1 = one-screen high, 2 = vertical, 3 = horizontal. A mirroring bit of 1 gives horizontal and 0 gives vertical.
- R4: In style 1, a write to 0x8000–0x9FFF with address bit 0 = 0 loads the control byte. With address bit 0 = 1, data bits 5:0 go to the slot named by control bits 2:0. Only slots 6 and 7 are kept, and data aimed at any other slot changes no window.
- R5: In style 1, windows 0–3 map to {slot 6, slot 7, 0x3E, 0x3F} when control bit 6 is 0. When control bit 6 is 1 they map to {0x3E, slot 7, slot 6, 0x3F}.
- R6: In style 1, a write to 0xA000–0xBFFF with address bit 0 = 0 loads the mirroring bit from data bit 0 (1 = horizontal, 0 = vertical). Odd addresses in that range are ignored.
- R7: In style 2 with serial control bit 3 = 1, banking is in 16 KB halves with bank value B = serial bank bits 3:0. If control bit 2 = 1, windows 0/1 map to 2B and 2B+1, and windows 2/3 map to 0x1E and 0x1F. If control bit 2 = 0, windows 0/1 map to 0 and 1, and windows 2/3 map to 2B and 2B+1.
- R8: In style 2 with serial control bit 3 = 0, window w maps to 4·(B>>1)+w.
- R9: In style 2, the mirror output equals serial control bits 1:0.
- R10: In style 3, the banks follow the style-0 rule and the mirror output keeps the value it had before style 3 was entered. Writes to the upper 32 KB are ignored in styles 2 and 3.
- R11: After reset, the style is 0 and the style-0 registers hold 0 and 1. Slots 6 and 7 hold 0x3C and 0x3D, the control byte and both mirroring bits are 0, and the mirror output is vertical.
- R12: The window is CPU address bits 14:13. The offset output equals CPU address bits 12:0, and both outputs follow the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | CPU write strobe for this cycle |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU access address to translate |
| ser_ctrl | input | 5 | Serial-style control register from the sibling block |
| ser_prg | input | 4 | Serial-style PRG bank register from the sibling block |
| prg_bank | output | 6 | 8 KB ROM bank index for the accessed window |
| prg_offset | output | 13 | Byte offset inside the 8 KB bank |
| mirror | output | 2 | Nametable mirroring selection |

## Verification
The bench keeps a behavioural model and compares it with the design on every clock. It drives directed write sequences for each style, with all four windows probed after every change. The windows tell apart a register that went to the wrong slot, a swapped order, and a mistaken fixed bank. The serial style is tried in all three size and half combinations with an odd bank value, so a missing halving or doubling shows. Style changes in and out of the reserved code show whether the mirroring is held and whether writes leak into registers while they should be ignored. A random phase then mixes style writes, aliased addresses and changing serial inputs.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    STYLE_SIMPLE   = 2'd0,
    STYLE_INDEXED  = 2'd1,
    STYLE_SERIAL   = 2'd2,
    STYLE_RESERVED = 2'd3
  } style_e;

  typedef enum logic [1:0] {
    MIR_ONE_LO = 2'd0,
    MIR_ONE_HI = 2'd1,
    MIR_VERT   = 2'd2,
    MIR_HORZ   = 2'd3
  } mirror_e;

  // indexed style: control byte fields and kept slots
  localparam int unsigned IDX_SEL_W     = 3;
  localparam int unsigned IDX_SWAP_BIT  = 6;
  localparam int unsigned IDX_SLOT_A    = 6;
  localparam int unsigned IDX_SLOT_B    = 7;

  // serial style: control fields used for program banking
  localparam int unsigned SER_SIZE_BIT  = 3;
  localparam int unsigned SER_HALF_BIT  = 2;

  function automatic mirror_e mir_from_bit(input logic b);
    return b ? MIR_HORZ : MIR_VERT;
  endfunction

endpackage

// File: rtl/mmt_reset_sync.sv
module mmt_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/mmt_write_decode.sv
module mmt_write_decode
  import mmt_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned BANK_W = 6,
  parameter int unsigned S0_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output style_e                style_o,
  output logic [1:0][S0_W-1:0]  s0_bank_o,
  output logic                  s0_mir_o,
  output logic                  idx_swap_o,
  output logic [BANK_W-1:0]     idx_ra_o,
  output logic [BANK_W-1:0]     idx_rb_o,
  output logic                  idx_mir_o
);

  // address bit positions used by the decode
  localparam int unsigned A_HI    = ADDR_W - 1;
  localparam int unsigned A_MODE  = ADDR_W - 2;
  localparam int unsigned A_MODE2 = 8;
  localparam int unsigned A_SEL   = ADDR_W - 3;
  localparam int unsigned A_NIB   = ADDR_W - 4;
  localparam int unsigned S0_REGS = 2;

  localparam logic [BANK_W-1:0] RA_RST = {BANK_W{1'b1}} - BANK_W'(3);
  localparam logic [BANK_W-1:0] RB_RST = {BANK_W{1'b1}} - BANK_W'(2);

  // state
  style_e                 style_q;
  logic                   s0_mir_q;
  logic [IDX_SEL_W-1:0]   idx_sel_q;
  logic                   idx_swap_q;
  logic [BANK_W-1:0]      idx_ra_q;
  logic [BANK_W-1:0]      idx_rb_q;
  logic                   idx_mir_q;

  // enables and next values
  logic                   hi_we;
  logic                   mode_we;
  logic [S0_REGS-1:0]     s0_bank_we;
  logic                   s0_mir_we;
  logic                   idx_ctrl_we;
  logic                   idx_ra_we;
  logic                   idx_rb_we;
  logic                   idx_mir_we;
  style_e                 style_d;
  logic [S0_W-1:0]        s0_bank_d;
  logic                   mir_bit_d;
  logic [IDX_SEL_W-1:0]   idx_sel_d;
  logic                   idx_swap_d;
  logic [BANK_W-1:0]      idx_slot_d;

  always_comb begin
    hi_we       = wr_en & wr_addr[A_HI];
    mode_we     = wr_en & ~wr_addr[A_HI] & wr_addr[A_MODE] & wr_addr[A_MODE2];

    s0_bank_we  = '0;
    s0_bank_we[wr_addr[A_SEL]] = hi_we & (style_q == STYLE_SIMPLE)
                                 & ~wr_addr[A_MODE] & ~wr_addr[A_NIB];
    s0_mir_we   = hi_we & (style_q == STYLE_SIMPLE)
                  & (wr_addr[A_MODE:A_NIB] == 3'b001);

    idx_ctrl_we = hi_we & (style_q == STYLE_INDEXED)
                  & (wr_addr[A_MODE:A_SEL] == 2'b00) & ~wr_addr[0];
    idx_ra_we   = hi_we & (style_q == STYLE_INDEXED)
                  & (wr_addr[A_MODE:A_SEL] == 2'b00) & wr_addr[0]
                  & (idx_sel_q == IDX_SEL_W'(IDX_SLOT_A));
    idx_rb_we   = hi_we & (style_q == STYLE_INDEXED)
                  & (wr_addr[A_MODE:A_SEL] == 2'b00) & wr_addr[0]
                  & (idx_sel_q == IDX_SEL_W'(IDX_SLOT_B));
    idx_mir_we  = hi_we & (style_q == STYLE_INDEXED)
                  & (wr_addr[A_MODE:A_SEL] == 2'b01) & ~wr_addr[0];

    style_d     = style_e'(wr_data[1:0]);
    s0_bank_d   = wr_data[S0_W-1:0];
    mir_bit_d   = wr_data[0];
    idx_sel_d   = wr_data[IDX_SEL_W-1:0];
    idx_swap_d  = wr_data[IDX_SWAP_BIT];
    idx_slot_d  = wr_data[BANK_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      style_q    <= STYLE_SIMPLE;
      s0_mir_q   <= 1'b0;
      idx_sel_q  <= '0;
      idx_swap_q <= 1'b0;
      idx_ra_q   <= RA_RST;
      idx_rb_q   <= RB_RST;
      idx_mir_q  <= 1'b0;
    end else begin
      if (mode_we)     style_q    <= style_d;
      if (s0_mir_we)   s0_mir_q   <= mir_bit_d;
      if (idx_ctrl_we) idx_sel_q  <= idx_sel_d;
      if (idx_ctrl_we) idx_swap_q <= idx_swap_d;
      if (idx_ra_we)   idx_ra_q   <= idx_slot_d;
      if (idx_rb_we)   idx_rb_q   <= idx_slot_d;
      if (idx_mir_we)  idx_mir_q  <= mir_bit_d;
    end
  end

  // simple-style bank registers, one per switchable window
  for (genvar gi = 0; gi < S0_REGS; gi++) begin : g_s0_reg
    logic [S0_W-1:0] bank_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank_q <= S0_W'(gi);
      end else if (s0_bank_we[gi]) begin
        bank_q <= s0_bank_d;
      end
    end
    assign s0_bank_o[gi] = bank_q;
  end

  assign style_o    = style_q;
  assign s0_mir_o   = s0_mir_q;
  assign idx_swap_o = idx_swap_q;
  assign idx_ra_o   = idx_ra_q;
  assign idx_rb_o   = idx_rb_q;
  assign idx_mir_o  = idx_mir_q;

  logic unused_bits;
  assign unused_bits = ^{wr_addr, wr_data};

endmodule

// File: rtl/mmt_window_map.sv
module mmt_window_map
  import mmt_pkg::*;
#(
  parameter int unsigned BANK_W = 6,
  parameter int unsigned S0_W   = 5,
  parameter int unsigned SER_W  = 4,
  parameter int unsigned WIN_W  = 2
) (
  input  style_e                style_i,
  input  logic [1:0][S0_W-1:0]  s0_bank_i,
  input  logic                  idx_swap_i,
  input  logic [BANK_W-1:0]     idx_ra_i,
  input  logic [BANK_W-1:0]     idx_rb_i,
  input  logic                  ser_size16_i,
  input  logic                  ser_low_sw_i,
  input  logic [SER_W-1:0]      ser_bank_i,
  input  logic [WIN_W-1:0]      win_i,
  output logic [BANK_W-1:0]     bank_o
);

  localparam int unsigned NUM_WIN  = 1 << WIN_W;
  localparam int unsigned HALF_WIN = NUM_WIN / 2;
  localparam logic [BANK_W-1:0] TOP_BANK  = {BANK_W{1'b1}};
  localparam logic [BANK_W-1:0] NEXT_BANK = TOP_BANK - BANK_W'(1);

  logic [BANK_W-1:0] simple_tab [NUM_WIN];
  logic [BANK_W-1:0] idx_tab    [NUM_WIN];
  logic [BANK_W-1:0] ser_tab    [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [WIN_W-1:0] WC = WIN_W'(w);

    // simple style: low windows switchable, the rest fixed at the top
    if (w < 2) begin : g_s0_sw
      assign simple_tab[w] = BANK_W'(s0_bank_i[w]);
    end else begin : g_s0_fix
      assign simple_tab[w] = BANK_W'((1 << S0_W) - NUM_WIN + w);
    end

    // indexed style: order depends on the swap bit
    if (w == 0) begin : g_idx0
      assign idx_tab[w] = idx_swap_i ? NEXT_BANK : idx_ra_i;
    end else if (w == 1) begin : g_idx1
      assign idx_tab[w] = idx_rb_i;
    end else if (w == 2) begin : g_idx2
      assign idx_tab[w] = idx_swap_i ? idx_ra_i : NEXT_BANK;
    end else begin : g_idx3
      assign idx_tab[w] = TOP_BANK;
    end

    // serial style: 16 KB halves or one 32 KB bank
    logic [SER_W-1:0] half_bank;
    if (w < HALF_WIN) begin : g_ser_lo
      assign half_bank = ser_low_sw_i ? ser_bank_i : '0;
    end else begin : g_ser_hi
      assign half_bank = ser_low_sw_i ? {SER_W{1'b1}} : ser_bank_i;
    end
    assign ser_tab[w] = ser_size16_i
                        ? BANK_W'({half_bank, WC[0]})
                        : BANK_W'({ser_bank_i[SER_W-1:1], WC});
  end

  always_comb begin
    unique case (style_i)
      STYLE_INDEXED: bank_o = idx_tab[win_i];
      STYLE_SERIAL:  bank_o = ser_tab[win_i];
      default:       bank_o = simple_tab[win_i];
    endcase
  end

endmodule

// File: rtl/mmt_mirror_sel.sv
module mmt_mirror_sel
  import mmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  style_e     style_i,
  input  logic       s0_mir_i,
  input  logic       idx_mir_i,
  input  logic [1:0] ser_mir_i,
  output mirror_e    mir_o
);

  mirror_e calc;
  mirror_e hold_q;
  logic    hold_en;

  always_comb begin
    hold_en = (style_i != STYLE_RESERVED);
    unique case (style_i)
      STYLE_SIMPLE:  calc = mir_from_bit(s0_mir_i);
      STYLE_INDEXED: calc = mir_from_bit(idx_mir_i);
      STYLE_SERIAL:  calc = mirror_e'(ser_mir_i);
      default:       calc = hold_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= MIR_VERT;
    end else if (hold_en) begin
      hold_q <= calc;
    end
  end

  assign mir_o = calc;

endmodule

// File: rtl/prg_bank_xlate.sv
module prg_bank_xlate
  import mmt_pkg::*;
#(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned BANK_W      = 6,
  parameter int unsigned OFF_W       = 13,
  parameter int unsigned S0_W        = 5,
  parameter int unsigned SER_W       = 4,
  parameter int unsigned SER_CTRL_W  = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [SER_CTRL_W-1:0] ser_ctrl,
  input  logic [SER_W-1:0]      ser_prg,
  output logic [BANK_W-1:0]     prg_bank,
  output logic [OFF_W-1:0]      prg_offset,
  output logic [1:0]            mirror
);

  localparam int unsigned WIN_W  = ADDR_W - 1 - OFF_W;
  localparam int unsigned WIN_LO = OFF_W;

  logic                  rst_sync_n;
  style_e                style_w;
  logic [1:0][S0_W-1:0]  s0_bank_w;
  logic                  s0_mir_w;
  logic                  idx_swap_w;
  logic [BANK_W-1:0]     idx_ra_w;
  logic [BANK_W-1:0]     idx_rb_w;
  logic                  idx_mir_w;
  logic [WIN_W-1:0]      window_w;
  mirror_e               mir_w;

  mmt_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sync_n)
  );

  mmt_write_decode #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .BANK_W (BANK_W),
    .S0_W   (S0_W)
  ) u_dec (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .style_o    (style_w),
    .s0_bank_o  (s0_bank_w),
    .s0_mir_o   (s0_mir_w),
    .idx_swap_o (idx_swap_w),
    .idx_ra_o   (idx_ra_w),
    .idx_rb_o   (idx_rb_w),
    .idx_mir_o  (idx_mir_w)
  );

  assign window_w = cpu_addr[WIN_LO +: WIN_W];

  mmt_window_map #(
    .BANK_W (BANK_W),
    .S0_W   (S0_W),
    .SER_W  (SER_W),
    .WIN_W  (WIN_W)
  ) u_map (
    .style_i      (style_w),
    .s0_bank_i    (s0_bank_w),
    .idx_swap_i   (idx_swap_w),
    .idx_ra_i     (idx_ra_w),
    .idx_rb_i     (idx_rb_w),
    .ser_size16_i (ser_ctrl[SER_SIZE_BIT]),
    .ser_low_sw_i (ser_ctrl[SER_HALF_BIT]),
    .ser_bank_i   (ser_prg),
    .win_i        (window_w),
    .bank_o       (prg_bank)
  );

  mmt_mirror_sel u_mir (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .style_i   (style_w),
    .s0_mir_i  (s0_mir_w),
    .idx_mir_i (idx_mir_w),
    .ser_mir_i (ser_ctrl[1:0]),
    .mir_o     (mir_w)
  );

  assign mirror     = mir_w;
  assign prg_offset = cpu_addr[OFF_W-1:0];

  logic unused_inputs;
  assign unused_inputs = ^{cpu_addr, ser_ctrl};

endmodule

// File: rtl/mmt_checker.sv
module mmt_checker #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned BANK_W     = 6,
  parameter int unsigned S0_W       = 5,
  parameter int unsigned SER_W      = 4,
  parameter int unsigned SER_CTRL_W = 5,
  parameter int unsigned WIN_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     wr_addr,
  input logic [DATA_W-1:0]     wr_data,
  input logic [1:0]            style,
  input logic [WIN_W-1:0]      window,
  input logic [BANK_W-1:0]     prg_bank,
  input logic [1:0]            mirror,
  input logic [SER_CTRL_W-1:0] ser_ctrl,
  input logic [SER_W-1:0]      ser_prg,
  input logic                  idx_swap,
  input logic [BANK_W-1:0]     idx_ra
);

  logic mode_hit;
  assign mode_hit = wr_en & ~wr_addr[ADDR_W-1] & wr_addr[ADDR_W-2] & wr_addr[8];

  p_mode_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode_hit |=> (style == $past(wr_data[1:0])));

  p_mode_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_hit |=> (style == $past(style)));

  p_simple_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((style == 2'd0 || style == 2'd3) && window == {WIN_W{1'b1}})
    |-> (prg_bank == BANK_W'((1 << S0_W) - 1)));

  p_idx_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (style == 2'd1 && window == {WIN_W{1'b1}}) |-> (prg_bank == {BANK_W{1'b1}}));

  p_idx_swap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (style == 2'd1 && idx_swap && window == WIN_W'(2)) |-> (prg_bank == idx_ra));

  p_ser_32k_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (style == 2'd2 && !ser_ctrl[3])
    |-> (prg_bank == BANK_W'({ser_prg[SER_W-1:1], window})));

  p_ser_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (style == 2'd2) |-> (mirror == ser_ctrl[1:0]));

  p_hold_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (style == 2'd3 && $past(style) == 2'd3) |-> $stable(mirror));

endmodule

bind prg_bank_xlate mmt_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .BANK_W     (BANK_W),
  .S0_W       (S0_W),
  .SER_W      (SER_W),
  .SER_CTRL_W (SER_CTRL_W),
  .WIN_W      (WIN_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .style    (style_w),
  .window   (window_w),
  .prg_bank (prg_bank),
  .mirror   (mirror),
  .ser_ctrl (ser_ctrl),
  .ser_prg  (ser_prg),
  .idx_swap (idx_swap_w),
  .idx_ra   (idx_ra_w)
);

// File: tb/prg_bank_xlate_tb_top.sv
module prg_bank_xlate_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] cpu_addr;
  logic [4:0]  ser_ctrl;
  logic [3:0]  ser_prg;
  logic [5:0]  prg_bank;
  logic [12:0] prg_offset;
  logic [1:0]  mirror;

  int tests_run = 0;
  int tests_failed = 0;

  prg_bank_xlate dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .cpu_addr   (cpu_addr),
    .ser_ctrl   (ser_ctrl),
    .ser_prg    (ser_prg),
    .prg_bank   (prg_bank),
    .prg_offset (prg_offset),
    .mirror     (mirror)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_mode, m_s0a, m_s0b, m_s0m, m_sel, m_swap, m_ra, m_rb, m_s1m, m_hold;
  int mir_now;

  function automatic int model_mirror();
    case (m_mode)
      0: return m_s0m ? 3 : 2;
      1: return m_s1m ? 3 : 2;
      2: return int'(ser_ctrl[1:0]);
      default: return m_hold;
    endcase
  endfunction

  function automatic int model_bank(input int a);
    int w = (a >> 13) & 3;
    int b = int'(ser_prg);
    case (m_mode)
      1: begin
        if (w == 0) return m_swap ? 62 : m_ra;
        if (w == 1) return m_rb;
        if (w == 2) return m_swap ? m_ra : 62;
        return 63;
      end
      2: begin
        if (ser_ctrl[3]) begin
          if (ser_ctrl[2]) return (w < 2) ? (2*b + (w % 2)) : (30 + (w % 2));
          return (w < 2) ? w : (2*b + (w % 2));
        end
        return 4*(b/2) + w;
      end
      default: begin
        if (w == 0) return m_s0a;
        if (w == 1) return m_s0b;
        return 28 + w;
      end
    endcase
  endfunction

  function automatic string bank_tag();
    case (m_mode)
      0: return "R2";
      1: return "R5";
      2: return ser_ctrl[3] ? "R7" : "R8";
      default: return "R10";
    endcase
  endfunction

  function automatic string mir_tag();
    case (m_mode)
      0: return "R3";
      1: return "R6";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_s0a = 0; m_s0b = 1; m_s0m = 0;
      m_sel = 0; m_swap = 0; m_ra = 60; m_rb = 61; m_s1m = 0; m_hold = 2;
    end else begin
      mir_now = model_mirror();
      if (m_mode != 3) m_hold = mir_now;
      if (wr_en) begin
        if (!wr_addr[15]) begin
          if ((wr_addr & 16'h4100) == 16'h4100) m_mode = int'(wr_data[1:0]);
        end else if (m_mode == 0) begin
          if (wr_addr[14:12] == 3'd0 || wr_addr[14:12] == 3'd2) begin
            if (wr_addr[13]) m_s0b = int'(wr_data[4:0]);
            else             m_s0a = int'(wr_data[4:0]);
          end else if (wr_addr[14:12] == 3'd1) begin
            m_s0m = int'(wr_data[0]);
          end
        end else if (m_mode == 1) begin
          if (wr_addr[14:13] == 2'd0) begin
            if (!wr_addr[0]) begin
              m_sel = int'(wr_data[2:0]);
              m_swap = int'(wr_data[6]);
            end else if (m_sel == 6) m_ra = int'(wr_data[5:0]);
            else if (m_sel == 7) m_rb = int'(wr_data[5:0]);
          end else if (wr_addr[14:13] == 2'd1 && !wr_addr[0]) begin
            m_s1m = int'(wr_data[0]);
          end
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic check(input int act, input int exp, input string tag);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check(int'(prg_bank), model_bank(int'(cpu_addr)), bank_tag());
    check(int'(mirror), model_mirror(), mir_tag());
    check(int'(prg_offset), int'(cpu_addr[12:0]), "R12");
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare_model();
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic sweep();
    for (int w = 0; w < 4; w++) begin
      cpu_addr = {1'b1, 2'(w), 13'($urandom)};
      tick();
    end
  endtask

  task automatic expect_bank(input int win, input int exp, input string tag);
    cpu_addr = {1'b1, 2'(win), 13'h0ABC};
    #1;
    check(int'(prg_bank), exp, tag);
    check(int'(prg_offset), 32'h0ABC, "R12");
  endtask

  task automatic expect_mir(input int exp, input string tag);
    #1;
    check(int'(mirror), exp, tag);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    cpu_addr = 16'h8000; ser_ctrl = '0; ser_prg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    expect_bank(0, 8'h00, "R11"); expect_bank(1, 8'h01, "R11");
    expect_bank(2, 8'h1E, "R11"); expect_bank(3, 8'h1F, "R11");
    expect_mir(2, "R11");
    sweep();

    // R2 / R3 simple style
    wr(16'h8000, 8'h07); expect_bank(0, 8'h07, "R2");
    wr(16'hA000, 8'h15); expect_bank(1, 8'h15, "R2");
    wr(16'h8123, 8'hFF); expect_bank(0, 8'h1F, "R2");
    expect_bank(2, 8'h1E, "R2");
    wr(16'h9000, 8'h01); expect_mir(3, "R3");
    sweep();

    // R1 decode: near misses leave the style alone
    wr(16'h4000, 8'h01); expect_bank(0, 8'h1F, "R1");
    wr(16'h0100, 8'h01); expect_bank(0, 8'h1F, "R1");
    wr(16'hC100, 8'h01); expect_bank(0, 8'h1F, "R1");
    wr(16'h4F00, 8'hFD); expect_bank(0, 8'h3C, "R1");
    expect_bank(1, 8'h3D, "R11"); expect_mir(2, "R11");

    // R4 / R5 / R6 indexed style
    wr(16'h8000, 8'h06); wr(16'h8001, 8'h12); expect_bank(0, 8'h12, "R4");
    wr(16'h9000, 8'h07); wr(16'h9001, 8'h2B); expect_bank(1, 8'h2B, "R4");
    wr(16'h8000, 8'h02); wr(16'h8001, 8'h3F);
    expect_bank(0, 8'h12, "R4"); expect_bank(1, 8'h2B, "R4");
    expect_bank(2, 8'h3E, "R5"); expect_bank(3, 8'h3F, "R5");
    wr(16'h8000, 8'h46);
    expect_bank(0, 8'h3E, "R5"); expect_bank(2, 8'h12, "R5");
    wr(16'hA000, 8'h01); expect_mir(3, "R6");
    wr(16'hA001, 8'h00); expect_mir(3, "R6");
    wr(16'hB000, 8'h00); expect_mir(2, "R6");
    wr(16'hA000, 8'h01); expect_mir(3, "R6");
    sweep();

    // R10 reserved style entered from indexed
    wr(16'h4100, 8'h03); expect_mir(3, "R10");
    expect_bank(0, 8'h1F, "R10"); expect_bank(1, 8'h15, "R10");
    wr(16'h8000, 8'h03); expect_bank(0, 8'h1F, "R10");
    wr(16'h9000, 8'h00); expect_mir(3, "R10");
    sweep();

    // R7 / R8 / R9 serial style
    wr(16'h4100, 8'h02);
    ser_prg = 4'd5; ser_ctrl = 5'h0E;
    expect_bank(0, 8'h0A, "R7"); expect_bank(1, 8'h0B, "R7");
    expect_bank(2, 8'h1E, "R7"); expect_bank(3, 8'h1F, "R7");
    expect_mir(2, "R9");
    ser_ctrl = 5'h0B;
    expect_bank(0, 8'h00, "R7"); expect_bank(1, 8'h01, "R7");
    expect_bank(2, 8'h0A, "R7"); expect_bank(3, 8'h0B, "R7");
    expect_mir(3, "R9");
    ser_ctrl = 5'h01;
    expect_bank(0, 8'h08, "R8"); expect_bank(3, 8'h0B, "R8");
    expect_mir(1, "R9");
    ser_ctrl = 5'h00; expect_mir(0, "R9");
    sweep();
    wr(16'h8000, 8'h55); wr(16'h8001, 8'h00); wr(16'hA000, 8'h00);

    // R10 hold from serial, then confirm ignored writes
    wr(16'h4100, 8'h03); expect_mir(0, "R10");
    ser_ctrl = 5'h03; tick(); expect_mir(0, "R10");
    wr(16'h4100, 8'h01);
    expect_bank(0, 8'h3E, "R10"); expect_bank(1, 8'h2B, "R10");
    expect_bank(2, 8'h12, "R10"); expect_mir(3, "R10");
    wr(16'h4100, 8'h00);
    expect_bank(0, 8'h1F, "R10"); expect_mir(3, "R10");

    // random mix, compared against the model each clock
    for (int i = 0; i < 600; i++) begin
      logic [15:0] a;
      int k = int'($urandom_range(0, 9));
      if (k == 0)      a = 16'h4100 | 16'($urandom & 32'h3EFF);
      else if (k < 3)  a = 16'($urandom & 32'h7FFF);
      else             a = 16'h8000 | 16'($urandom & 32'h3003);
      ser_ctrl = 5'($urandom);
      ser_prg  = 4'($urandom);
      cpu_addr = 16'h8000 | 16'($urandom);
      wr(a, 8'($urandom));
      cpu_addr = 16'h8000 | 16'($urandom);
      tick();
    end

    summary();
    $finish;
  end

endmodule